// File: doc/BRIEF.md
# Programmable Reversible Gate Cascade

This block evaluates a reversible logic circuit on a bundle of `WIRES` bits. A program of up to `DEPTH` gates is written into a small gate memory through a plain write port, together with a program length. Each gate is either a multi-controlled inverter or a wire exchange. A multi-controlled inverter is described by two masks: a control mask and a target mask. A wire exchange is described by two wire indices. Because every gate is its own inverse, the block can play the stored list either first-to-last or last-to-first. The second order yields the inverse permutation of the first.

Input vectors arrive on a valid/ready stream and results leave on another. One vector is in flight at a time. The block applies one gate per clock, then holds the result until the consumer takes it. `in_ready` is high only while the block is idle. A result stays on `out_vec` with `out_valid` high for as long as `out_ready` is low. Program writes are taken only while the block is idle. A malformed gate or an oversized length is refused and raises a sticky error flag.

Top module: `rev_cascade`

## Requirements
- R1: A controlled-inverter gate flips every wire set in its target mask only when every wire set in its control mask is 1. Control wires and all other wires keep their values. An empty control mask gives an unconditional inverter, and two control bits give a three-wire controlled-controlled inverter.
- R2: A swap gate (`prog_is_swap`=1) exchanges the values of wires `prog_wa` and `prog_wb` and leaves all other wires alone.
- R3: With `in_rev`=0, gates are applied at addresses 0, 1, ..., len-1 in that order. On the low three wires, the program {ctrl 0110 / tgt 0001, tgt 0100, ctrl 0110 / tgt 0001, tgt 0100} exchanges 2 with 3 and 6 with 7 and fixes every other input.
- R4: With `in_rev`=1, gates are applied at addresses len-1 down to 0, so the output is the inverse of the forward permutation.
- R5: A program length of zero makes the block the identity. The result is valid on the same clock edge that accepts the input.
- R6: For a length L, `out_valid` rises exactly L clock edges after the edge that accepted the input.
- R7: `in_ready` is high only while the block is idle, and never while `out_valid` is high. While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_vec` holds steady.
- R8: A controlled-inverter write whose control and target masks share a set bit is not stored and sets `prog_err`. `prog_err` stays set until reset.
- R9: A swap write whose two wire indices are equal is not stored and sets `prog_err`.
- R10: A length write larger than `DEPTH` is not stored and sets `prog_err`.
- R11: Gate and length writes made while `in_ready`=0 are ignored and do not set `prog_err`. A gate write in the same cycle that an input is accepted is stored and is used by that evaluation.
- R12: A program made only of two-control inverters maps 0 and every one-hot input to themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears gates, length, error and state |
| prog_we | input | 1 | Gate write strobe |
| prog_addr | input | $clog2(DEPTH) | Gate address |
| prog_is_swap | input | 1 | 1: swap gate, 0: controlled inverter |
| prog_ctrl | input | WIRES | Control mask |
| prog_tgt | input | WIRES | Target mask |
| prog_wa | input | $clog2(WIRES) | First swap wire |
| prog_wb | input | $clog2(WIRES) | Second swap wire |
| len_we | input | 1 | Length write strobe |
| len_val | input | $clog2(DEPTH+1) | Number of gates to run |
| prog_err | output | 1 | Sticky malformed-write flag |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block idle, input accepted |
| in_vec | input | WIRES | Input vector |
| in_rev | input | 1 | Run the program last-to-first |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_vec | output | WIRES | Permuted vector |

## Verification
A gate write and an input acceptance can land on the same clock edge. They cross in the gate memory: the sequencer reads its first gate one cycle after acceptance. The bench provokes this by raising `prog_write` and `in_valid` together while the block is idle, replacing the last gate of a three-gate program. The output is judged against the permutation with the new gate, not the old one. The opposite case is also provoked: a write that arrives while the cascade is running. The bench judges it by two later results that still follow the old program, with `prog_err` still low.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  typedef enum logic {
    GK_CINV = 1'b0,
    GK_SWAP = 1'b1
  } gate_kind_e;

endpackage

// File: rtl/rcg_gate_store.sv
module rcg_gate_store #(
  parameter int WIRES = 4,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(WIRES),
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_open,
  input  logic                  g_we,
  input  logic [AW-1:0]         g_addr,
  input  rcg_pkg::gate_kind_e   g_kind,
  input  logic [WIRES-1:0]      g_ctrl,
  input  logic [WIRES-1:0]      g_tgt,
  input  logic [IW-1:0]         g_wa,
  input  logic [IW-1:0]         g_wb,
  input  logic                  l_we,
  input  logic [LW-1:0]         l_val,
  input  logic [AW-1:0]         rd_idx,
  output rcg_pkg::gate_kind_e   rd_kind,
  output logic [WIRES-1:0]      rd_ctrl,
  output logic [WIRES-1:0]      rd_tgt,
  output logic [IW-1:0]         rd_wa,
  output logic [IW-1:0]         rd_wb,
  output logic [LW-1:0]         len_o,
  output logic                  err_o
);
  import rcg_pkg::*;

  gate_kind_e        kind_q [DEPTH];
  logic [WIRES-1:0]  ctrl_q [DEPTH];
  logic [WIRES-1:0]  tgt_q  [DEPTH];
  logic [IW-1:0]     wa_q   [DEPTH];
  logic [IW-1:0]     wb_q   [DEPTH];
  logic [LW-1:0]     len_q;
  logic              err_q;

  logic gate_bad;
  logic len_bad;
  logic gate_take;
  logic len_take;

  always_comb begin
    if (g_kind == GK_SWAP) begin
      gate_bad = (g_wa == g_wb);
    end else begin
      gate_bad = |(g_ctrl & g_tgt);
    end
    len_bad   = (l_val > LW'(DEPTH));
    gate_take = wr_open && g_we && !gate_bad;
    len_take  = wr_open && l_we && !len_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= GK_CINV;
        ctrl_q[i] <= '0;
        tgt_q[i]  <= '0;
        wa_q[i]   <= '0;
        wb_q[i]   <= '0;
      end
    end else if (gate_take) begin
      kind_q[g_addr] <= g_kind;
      ctrl_q[g_addr] <= g_ctrl;
      tgt_q[g_addr]  <= g_tgt;
      wa_q[g_addr]   <= g_wa;
      wb_q[g_addr]   <= g_wb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (len_take) begin
        len_q <= l_val;
      end
      if (wr_open && ((g_we && gate_bad) || (l_we && len_bad))) begin
        err_q <= 1'b1;
      end
    end
  end

  assign rd_kind = kind_q[rd_idx];
  assign rd_ctrl = ctrl_q[rd_idx];
  assign rd_tgt  = tgt_q[rd_idx];
  assign rd_wa   = wa_q[rd_idx];
  assign rd_wb   = wb_q[rd_idx];
  assign len_o   = len_q;
  assign err_o   = err_q;

endmodule

// File: rtl/rcg_gate_apply.sv
module rcg_gate_apply #(
  parameter int WIRES = 4,
  localparam int IW = $clog2(WIRES)
) (
  input  logic [WIRES-1:0]    vec_i,
  input  rcg_pkg::gate_kind_e kind,
  input  logic [WIRES-1:0]    ctrl,
  input  logic [WIRES-1:0]    tgt,
  input  logic [IW-1:0]       wa,
  input  logic [IW-1:0]       wb,
  output logic [WIRES-1:0]    vec_o
);
  import rcg_pkg::*;

  logic             fire;
  logic [WIRES-1:0] cinv_v;
  logic [WIRES-1:0] swap_v;

  assign fire = ((vec_i & ctrl) == ctrl);

  for (genvar w = 0; w < WIRES; w++) begin : g_wire
    assign cinv_v[w] = vec_i[w] ^ (tgt[w] & fire);
    assign swap_v[w] = (wa == IW'(w)) ? vec_i[wb] :
                       (wb == IW'(w)) ? vec_i[wa] : vec_i[w];
  end

  assign vec_o = (kind == GK_SWAP) ? swap_v : cinv_v;

endmodule

// File: rtl/rcg_sequencer.sv
module rcg_sequencer #(
  parameter int WIRES = 4,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_rev,
  input  logic [WIRES-1:0] in_vec,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIRES-1:0] out_vec,
  input  logic [LW-1:0]    len_i,
  output logic [AW-1:0]    rd_idx,
  output logic [WIRES-1:0] cur_vec,
  input  logic [WIRES-1:0] nxt_vec
);
  import rcg_pkg::*;

  seq_state_e       st_q;
  logic [WIRES-1:0] vec_q;
  logic [AW-1:0]    idx_q;
  logic [LW-1:0]    left_q;
  logic             rev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      vec_q  <= '0;
      idx_q  <= '0;
      left_q <= '0;
      rev_q  <= 1'b0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (in_valid) begin
            vec_q  <= in_vec;
            rev_q  <= in_rev;
            left_q <= len_i;
            idx_q  <= in_rev ? AW'(len_i - LW'(1)) : '0;
            st_q   <= (len_i == '0) ? SEQ_DONE : SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          vec_q  <= nxt_vec;
          left_q <= left_q - LW'(1);
          idx_q  <= rev_q ? idx_q - AW'(1) : idx_q + AW'(1);
          if (left_q == LW'(1)) begin
            st_q <= SEQ_DONE;
          end
        end
        SEQ_DONE: begin
          if (out_ready) begin
            st_q <= SEQ_IDLE;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign in_ready  = (st_q == SEQ_IDLE);
  assign out_valid = (st_q == SEQ_DONE);
  assign out_vec   = vec_q;
  assign rd_idx    = idx_q;
  assign cur_vec   = vec_q;

endmodule

// File: rtl/rev_cascade.sv
module rev_cascade #(
  parameter int WIRES = 4,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(WIRES),
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_we,
  input  logic [AW-1:0]    prog_addr,
  input  logic             prog_is_swap,
  input  logic [WIRES-1:0] prog_ctrl,
  input  logic [WIRES-1:0] prog_tgt,
  input  logic [IW-1:0]    prog_wa,
  input  logic [IW-1:0]    prog_wb,
  input  logic             len_we,
  input  logic [LW-1:0]    len_val,
  output logic             prog_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIRES-1:0] in_vec,
  input  logic             in_rev,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIRES-1:0] out_vec
);
  import rcg_pkg::*;

  gate_kind_e       wr_kind;
  gate_kind_e       rd_kind;
  logic [WIRES-1:0] rd_ctrl;
  logic [WIRES-1:0] rd_tgt;
  logic [IW-1:0]    rd_wa;
  logic [IW-1:0]    rd_wb;
  logic [AW-1:0]    rd_idx;
  logic [LW-1:0]    len_q;
  logic [WIRES-1:0] cur_vec;
  logic [WIRES-1:0] nxt_vec;
  logic             idle;

  assign wr_kind  = prog_is_swap ? GK_SWAP : GK_CINV;
  assign in_ready = idle;

  rcg_gate_store #(.WIRES(WIRES), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_open (idle),
    .g_we    (prog_we),
    .g_addr  (prog_addr),
    .g_kind  (wr_kind),
    .g_ctrl  (prog_ctrl),
    .g_tgt   (prog_tgt),
    .g_wa    (prog_wa),
    .g_wb    (prog_wb),
    .l_we    (len_we),
    .l_val   (len_val),
    .rd_idx  (rd_idx),
    .rd_kind (rd_kind),
    .rd_ctrl (rd_ctrl),
    .rd_tgt  (rd_tgt),
    .rd_wa   (rd_wa),
    .rd_wb   (rd_wb),
    .len_o   (len_q),
    .err_o   (prog_err)
  );

  rcg_gate_apply #(.WIRES(WIRES)) u_apply (
    .vec_i (cur_vec),
    .kind  (rd_kind),
    .ctrl  (rd_ctrl),
    .tgt   (rd_tgt),
    .wa    (rd_wa),
    .wb    (rd_wb),
    .vec_o (nxt_vec)
  );

  rcg_sequencer #(.WIRES(WIRES), .DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_rev    (in_rev),
    .in_vec    (in_vec),
    .in_ready  (idle),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vec   (out_vec),
    .len_i     (len_q),
    .rd_idx    (rd_idx),
    .cur_vec   (cur_vec),
    .nxt_vec   (nxt_vec)
  );

endmodule

// File: rtl/rev_cascade_chk.sv
module rev_cascade_chk #(
  parameter int WIRES = 4,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(WIRES),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIRES-1:0] in_vec,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIRES-1:0] out_vec,
  input logic             prog_we,
  input logic             prog_is_swap,
  input logic [WIRES-1:0] prog_ctrl,
  input logic [WIRES-1:0] prog_tgt,
  input logic [IW-1:0]    prog_wa,
  input logic [IW-1:0]    prog_wb,
  input logic             prog_err,
  input logic [LW-1:0]    len_q
);

  a_r5_zero_len_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && len_q == '0) |=> (out_valid && out_vec == $past(in_vec)));

  a_r6_not_done_early: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && len_q != '0) |=> !out_valid);

  a_r7_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

  a_r8_overlap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && in_ready && !prog_is_swap && (prog_ctrl & prog_tgt) != '0) |=> prog_err);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |=> prog_err);

  a_r9_swap_same_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && in_ready && prog_is_swap && prog_wa == prog_wb) |=> prog_err);

endmodule

bind rev_cascade rev_cascade_chk #(.WIRES(WIRES), .DEPTH(DEPTH)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_vec       (in_vec),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_vec      (out_vec),
  .prog_we      (prog_we),
  .prog_is_swap (prog_is_swap),
  .prog_ctrl    (prog_ctrl),
  .prog_tgt     (prog_tgt),
  .prog_wa      (prog_wa),
  .prog_wb      (prog_wb),
  .prog_err     (prog_err),
  .len_q        (len_q)
);

// File: tb/test_rev_cascade.sv
`timescale 1ns/1ps
module test_rev_cascade;
  localparam int W  = 4;
  localparam int D  = 16;
  localparam int IW = $clog2(W);
  localparam int AW = $clog2(D);
  localparam int LW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic prog_is_swap = 1'b0;
  logic [W-1:0] prog_ctrl = '0;
  logic [W-1:0] prog_tgt = '0;
  logic [IW-1:0] prog_wa = '0;
  logic [IW-1:0] prog_wb = '0;
  logic len_we = 1'b0;
  logic [LW-1:0] len_val = '0;
  logic prog_err;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_vec = '0;
  logic in_rev = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [W-1:0] out_vec;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rev_cascade #(.WIRES(W), .DEPTH(D)) i_rev_cascade (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_is_swap(prog_is_swap), .prog_ctrl(prog_ctrl), .prog_tgt(prog_tgt),
    .prog_wa(prog_wa), .prog_wb(prog_wb), .len_we(len_we), .len_val(len_val),
    .prog_err(prog_err), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .in_rev(in_rev), .out_valid(out_valid),
    .out_ready(out_ready), .out_vec(out_vec)
  );

  // entry: {program id[10:9], reverse[8], input[7:4], expected[3:0]}
  localparam int NV = 27;
  localparam logic [10:0] TBL [NV] = '{
    {2'd0,1'b0,4'd2,4'd3},   {2'd0,1'b0,4'd3,4'd2},   {2'd0,1'b0,4'd6,4'd7},
    {2'd0,1'b0,4'd7,4'd6},   {2'd0,1'b0,4'd0,4'd0},   {2'd0,1'b0,4'd1,4'd1},
    {2'd0,1'b0,4'd4,4'd4},   {2'd0,1'b0,4'd5,4'd5},   {2'd0,1'b0,4'd10,4'd11},
    {2'd0,1'b1,4'd6,4'd7},
    {2'd1,1'b0,4'd1,4'd12},  {2'd1,1'b0,4'd8,4'd7},   {2'd1,1'b0,4'd0,4'd4},
    {2'd1,1'b0,4'd3,4'd14},  {2'd1,1'b1,4'd12,4'd1},  {2'd1,1'b1,4'd7,4'd8},
    {2'd1,1'b1,4'd4,4'd0},   {2'd1,1'b1,4'd3,4'd12},
    {2'd2,1'b0,4'd0,4'd0},   {2'd2,1'b0,4'd1,4'd1},   {2'd2,1'b0,4'd2,4'd2},
    {2'd2,1'b0,4'd4,4'd4},   {2'd2,1'b0,4'd8,4'd8},   {2'd2,1'b0,4'd3,4'd14},
    {2'd2,1'b1,4'd0,4'd0},   {2'd2,1'b1,4'd8,4'd8},   {2'd2,1'b1,4'd14,4'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; prog_we = 1'b0; len_we = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wgate(input int a, input bit sw, input int c, input int t, input int x, input int y);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = AW'(a); prog_is_swap = sw;
    prog_ctrl = W'(c); prog_tgt = W'(t); prog_wa = IW'(x); prog_wb = IW'(y);
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wlen(input int n);
    @(negedge clk);
    len_we = 1'b1; len_val = LW'(n);
    @(negedge clk);
    len_we = 1'b0;
  endtask

  task automatic load_prog(input int id);
    if (id == 0) begin
      wgate(0, 0, 6, 1, 0, 0); wgate(1, 0, 0, 4, 0, 0);
      wgate(2, 0, 6, 1, 0, 0); wgate(3, 0, 0, 4, 0, 0); wlen(4);
    end else if (id == 1) begin
      wgate(0, 1, 0, 0, 0, 3); wgate(1, 0, 1, 2, 0, 0);
      wgate(2, 0, 0, 4, 0, 0); wlen(3);
    end else begin
      wgate(0, 0, 3, 4, 0, 0); wgate(1, 0, 6, 8, 0, 0);
      wgate(2, 0, 12, 1, 0, 0); wlen(3);
    end
  endtask

  // wait for a result after the accepting edge; lat counts edges past it
  task automatic wait_out(output int v, output int lat);
    lat = 0;
    while (!out_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    v = int'(out_vec);
  endtask

  task automatic run_vec(input int vin, input bit rev, output int v, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_vec = W'(vin); in_rev = rev;
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(v, lat);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, lat, cur, len;
    do_reset();
    check(in_ready == 1'b1, "R7 reset in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
    check(prog_err == 1'b0, "R8 reset prog_err", int'(prog_err), 0);

    // R5: length zero after reset
    run_vec(9, 1'b0, v, lat);
    check(v == 9, "R5 identity value", v, 9);
    check(lat == 0, "R5 identity latency", lat, 0);
    run_vec(5, 1'b1, v, lat);
    check(v == 5, "R5 identity reverse", v, 5);

    cur = -1;
    len = 0;
    for (int i = 0; i < NV; i++) begin
      int pid, rv, vin, exp;
      pid = int'(TBL[i][10:9]);
      rv  = int'(TBL[i][8]);
      vin = int'(TBL[i][7:4]);
      exp = int'(TBL[i][3:0]);
      if (pid != cur) begin
        load_prog(pid);
        cur = pid;
        len = (pid == 0) ? 4 : 3;
      end
      run_vec(vin, rv[0], v, lat);
      if (pid == 0)      check(v == exp, "R1 R3 toffoli-not chain", v, exp);
      else if (pid == 2) check(v == exp, "R12 toffoli-only program", v, exp);
      else if (rv == 0)  check(v == exp, "R2 swap program forward", v, exp);
      else               check(v == exp, "R4 reverse gives inverse", v, exp);
      check(lat == len, "R6 one gate per cycle", lat, len);
    end

    // R7: back-pressure on prog 2 (loaded last)
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_vec = 4'd3; in_rev = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(v, lat);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
      check(int'(out_vec) == 14, "R7 value held", int'(out_vec), 14);
      check(in_ready == 1'b0, "R7 no input while full", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 released", int'(out_valid), 0);
    check(in_ready == 1'b1, "R7 idle again", int'(in_ready), 1);

    // R11: write during run is dropped
    load_prog(0);
    @(negedge clk);
    in_valid = 1'b1; in_vec = 4'd2; in_rev = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    prog_we = 1'b1; prog_addr = '0; prog_is_swap = 1'b0; prog_ctrl = '0; prog_tgt = 4'd8;
    len_we = 1'b1; len_val = LW'(1);
    @(negedge clk);
    prog_we = 1'b0; len_we = 1'b0;
    wait_out(v, lat);
    @(negedge clk);
    check(v == 3, "R11 busy write no effect now", v, 3);
    run_vec(2, 1'b0, v, lat);
    check(v == 3, "R11 busy write not stored", v, 3);
    check(lat == 4, "R11 busy length not stored", lat, 4);
    check(prog_err == 1'b0, "R11 busy write no error", int'(prog_err), 0);

    // R11: gate write on the accepting edge is used
    load_prog(1);
    @(negedge clk);
    in_valid = 1'b1; in_vec = 4'd0; in_rev = 1'b0;
    prog_we = 1'b1; prog_addr = AW'(2); prog_is_swap = 1'b0; prog_ctrl = '0; prog_tgt = 4'd8;
    @(negedge clk);
    in_valid = 1'b0; prog_we = 1'b0;
    wait_out(v, lat);
    @(negedge clk);
    check(v == 8, "R11 same-cycle write used", v, 8);

    // R8: overlapping masks
    load_prog(0);
    wgate(0, 0, 3, 2, 0, 0);
    check(prog_err == 1'b1, "R8 overlap flagged", int'(prog_err), 1);
    run_vec(2, 1'b0, v, lat);
    check(v == 3, "R8 overlap not stored", v, 3);
    check(prog_err == 1'b1, "R8 flag sticky", int'(prog_err), 1);

    // R9: swap of a wire with itself
    do_reset();
    check(prog_err == 1'b0, "R9 cleared by reset", int'(prog_err), 0);
    load_prog(1);
    wgate(0, 1, 0, 0, 2, 2);
    check(prog_err == 1'b1, "R9 equal swap flagged", int'(prog_err), 1);
    run_vec(1, 1'b0, v, lat);
    check(v == 12, "R9 equal swap not stored", v, 12);

    // R10: oversize length
    do_reset();
    load_prog(1);
    wlen(D + 1);
    check(prog_err == 1'b1, "R10 long length flagged", int'(prog_err), 1);
    run_vec(8, 1'b0, v, lat);
    check(v == 7, "R10 length kept value", v, 7);
    check(lat == 3, "R10 length kept latency", lat, 3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule